// File: doc/BRIEF.md
# Mask-Driven Byte Shuffle

This block assembles a 64-bit result from any eight of the sixteen bytes held in two 64-bit operands. The operands are joined into one 16-byte pool, and each result byte is chosen by its own 4-bit selector. The eight selectors come from the upper half of a 64-bit status word, which some other block loads. This block only reads that word.

The unit is a single pipeline stage. An operation presented with `in_valid` high is captured on the next rising clock edge. It then appears on `result` together with `out_valid`. While no operation is presented, the result register keeps its last value. Typical uses include byte-order reversal, lane broadcast, unaligned extraction across two words and interleaving of the two operands.

Top module: `byte_shuffle_unit`

## Requirements
- R1: The selector mask is taken only from status_word[63:32]. Bits 31:0 of the status word have no effect on the result.
- R2: Selector i (i = 0..7) occupies status_word bits (63-4i) down to (60-4i). Selector 0 chooses the most significant result byte, result[63:56], and selector 7 chooses result[7:0].
- R3: Pool index k (0..15) names byte k of the concatenation {src_a, src_b}. Index 0 is src_a[63:56], index 7 is src_a[7:0], index 8 is src_b[63:56] and index 15 is src_b[7:0].
- R4: Selectors are independent, so one pool byte may appear in several result bytes or in all of them.
- R5: The mask 0x01234567 returns src_a unchanged.
- R6: The mask 0x89ABCDEF returns src_b unchanged.
- R7: out_valid equals the value in_valid had at the previous rising clock edge.
- R8: When in_valid is low at a rising edge, result keeps its value, whatever the other inputs do.
- R9: A clock edge with rst_n low clears result to zero and out_valid to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| status_word | input | 64 | Status word; bits 63:32 hold eight 4-bit byte selectors |
| src_a | input | 64 | First operand, pool bytes 0 to 7 |
| src_b | input | 64 | Second operand, pool bytes 8 to 15 |
| in_valid | input | 1 | An operation is presented this cycle |
| result | output | 64 | Shuffled word, registered |
| out_valid | output | 1 | result holds a new operation this cycle |

## Verification
The properties assume that the status word, the operands and in_valid are steady around each rising edge. They also assume that reset is applied from time zero, so every property has a known previous cycle to refer to. The bench meets these conditions by changing every input only on falling edges and by holding rst_n low for the first cycles. During idle stretches it changes the operands and the low half of the status word, which tests the hold property against stimulus that would otherwise have altered the result.

// File: rtl/bshuf_pkg.sv
// Shared constants for the byte shuffle unit.
// Assumes the word width is a whole number of bytes.
package bshuf_pkg;
    localparam int unsigned DEF_WORD_W = 64;
    localparam int unsigned DEF_BYTE_W = 8;
endpackage

// File: rtl/bshuf_lane.sv
// One result byte: picks a byte out of the pool by index.
// Assumes pool index 0 sits at the most significant end of the pool vector.
module bshuf_lane #(
    parameter int unsigned BYTE_W     = bshuf_pkg::DEF_BYTE_W,
    parameter int unsigned POOL_BYTES = 16,
    parameter int unsigned IDX_W      = $clog2(POOL_BYTES)
) (
    input  logic [POOL_BYTES*BYTE_W-1:0] pool,
    input  logic [IDX_W-1:0]             sel,
    output logic [BYTE_W-1:0]            pick
);
    // Mux across the pool; index k counts bytes down from the top.
    always_comb begin
        pick = '0;
        for (int k = 0; k < int'(POOL_BYTES); k++) begin
            if (sel == IDX_W'(k)) begin
                pick = pool[(int'(POOL_BYTES) - 1 - k)*int'(BYTE_W) +: int'(BYTE_W)];
            end
        end
    end
endmodule

// File: rtl/bshuf_core.sv
// Combinational shuffle: builds the pool from two operands and applies
// one selector per result byte. Assumes the selector for result byte 0
// (the most significant byte) is the most significant field of mask.
module bshuf_core #(
    parameter int unsigned WORD_W = bshuf_pkg::DEF_WORD_W,
    parameter int unsigned BYTE_W = bshuf_pkg::DEF_BYTE_W,
    localparam int unsigned LANES  = WORD_W / BYTE_W,
    localparam int unsigned POOL   = 2 * LANES,
    localparam int unsigned IDX_W  = $clog2(POOL),
    localparam int unsigned MASK_W = LANES * IDX_W
) (
    input  logic [MASK_W-1:0] mask,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic [WORD_W-1:0] shuffled
);
    logic [2*WORD_W-1:0] pool;

    // First operand forms the upper (low-index) half of the pool.
    assign pool = {op_a, op_b};

    for (genvar i = 0; i < int'(LANES); i++) begin : g_lane
        logic [IDX_W-1:0] sel_i;
        assign sel_i = mask[MASK_W - 1 - i*IDX_W -: IDX_W];
        bshuf_lane #(
            .BYTE_W     (BYTE_W),
            .POOL_BYTES (POOL),
            .IDX_W      (IDX_W)
        ) u_lane (
            .pool (pool),
            .sel  (sel_i),
            .pick (shuffled[WORD_W - 1 - i*BYTE_W -: BYTE_W])
        );
    end
endmodule

// File: rtl/byte_shuffle_unit.sv
// Top: registered byte shuffle. Reads the selector mask from the upper
// half of the status word and captures the shuffled word when in_valid
// is high. Assumes the status word is loaded elsewhere and held steady.
module byte_shuffle_unit #(
    parameter int unsigned WORD_W = bshuf_pkg::DEF_WORD_W,
    parameter int unsigned BYTE_W = bshuf_pkg::DEF_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] status_word,
    input  logic [WORD_W-1:0] src_a,
    input  logic [WORD_W-1:0] src_b,
    input  logic              in_valid,
    output logic [WORD_W-1:0] result,
    output logic              out_valid
);
    localparam int unsigned LANES    = WORD_W / BYTE_W;
    localparam int unsigned IDX_W    = $clog2(2 * LANES);
    localparam int unsigned MASK_W   = LANES * IDX_W;
    localparam int unsigned MASK_LSB = WORD_W - MASK_W;

    logic [MASK_W-1:0] mask;
    logic [WORD_W-1:0] shuffled;
    logic              unused_low;

    // Only the upper field of the status word steers the shuffle.
    assign mask       = status_word[MASK_LSB +: MASK_W];
    assign unused_low = ^status_word[MASK_LSB-1:0];

    bshuf_core #(
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W)
    ) u_core (
        .mask     (mask),
        .op_a     (src_a),
        .op_b     (src_b),
        .shuffled (shuffled)
    );

    // Output stage: capture on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= shuffled;
            end
        end
    end
endmodule

// File: rtl/byte_shuffle_unit_chk.sv
// Checker for the byte shuffle unit, attached to the top by bind.
// Assumes reset is applied from time zero.
module byte_shuffle_unit_chk #(
    parameter int unsigned WORD_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] status_word,
    input logic [WORD_W-1:0] src_a,
    input logic [WORD_W-1:0] src_b,
    input logic              in_valid,
    input logic [WORD_W-1:0] result,
    input logic              out_valid
);
    logic unused_low;
    assign unused_low = ^status_word[WORD_W/2-1:0];

    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_no_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    assert_identity_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && status_word[WORD_W-1 -: 32] == 32'h01234567) |=> result == $past(src_a));

    assert_identity_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && status_word[WORD_W-1 -: 32] == 32'h89ABCDEF) |=> result == $past(src_b));
endmodule

bind byte_shuffle_unit byte_shuffle_unit_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .status_word (status_word),
    .src_a       (src_a),
    .src_b       (src_b),
    .in_valid    (in_valid),
    .result      (result),
    .out_valid   (out_valid)
);

// File: tb/byte_shuffle_unit_tb.sv
module byte_shuffle_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] status_word = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        in_valid = 1'b0;
    logic [63:0] result;
    logic        out_valid;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    byte_shuffle_unit u_dut (
        .clk(clk), .rst_n(rst_n), .status_word(status_word),
        .src_a(src_a), .src_b(src_b), .in_valid(in_valid),
        .result(result), .out_valid(out_valid)
    );

    localparam int NV = 10;
    // status, src_a, src_b, expected, requirement number
    localparam logic [63:0] V_ST [NV] = '{
        64'h01234567_00000000,   // R5
        64'h89ABCDEF_00000000,   // R6
        64'hFEDCBA98_00000000,   // R3 reversed second operand
        64'h76543210_00000000,   // R3 reversed first operand
        64'h55555555_00000000,   // R4 broadcast
        64'h0F1E2D3C_00000000,   // R2 selector positions
        64'h70000000_00000000,   // R2 single selector
        64'h01234567_FFFFFFFF,   // R1 low half ignored
        64'h08192A3B_A5A5A5A5,   // R1/R3 interleave
        64'h01234567_12345678    // R5 second data set
    };
    localparam logic [63:0] V_A [NV] = '{
        64'h0011223344556677, 64'h0011223344556677, 64'h0011223344556677,
        64'h0011223344556677, 64'h0011223344556677, 64'h0011223344556677,
        64'h0011223344556677, 64'h0011223344556677, 64'h0123456789ABCDEF,
        64'h0123456789ABCDEF
    };
    localparam logic [63:0] V_B [NV] = '{
        64'h8899AABBCCDDEEFF, 64'h8899AABBCCDDEEFF, 64'h8899AABBCCDDEEFF,
        64'h8899AABBCCDDEEFF, 64'h8899AABBCCDDEEFF, 64'h8899AABBCCDDEEFF,
        64'h8899AABBCCDDEEFF, 64'h8899AABBCCDDEEFF, 64'hFEDCBA9876543210,
        64'hFEDCBA9876543210
    };
    localparam logic [63:0] V_EXP [NV] = '{
        64'h0011223344556677, 64'h8899AABBCCDDEEFF, 64'hFFEEDDCCBBAA9988,
        64'h7766554433221100, 64'h5555555555555555, 64'h00FF11EE22DD33CC,
        64'h7700000000000000, 64'h0011223344556677, 64'h01FE23DC45BA6798,
        64'h0123456789ABCDEF
    };
    localparam int V_REQ [NV] = '{5, 6, 3, 3, 4, 2, 2, 1, 3, 5};

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R9: state after reset
        check("R9 result", result, 64'h0);
        check("R9 out_valid", {63'h0, out_valid}, 64'h0);
        rst_n = 1'b1;

        // Vector table, one operation per cycle
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            status_word = V_ST[v]; src_a = V_A[v]; src_b = V_B[v]; in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("R%0d vector %0d", V_REQ[v], v), result, V_EXP[v]);
            check("R7 out_valid high", {63'h0, out_valid}, 64'h1);
        end

        // R7/R8: idle cycles with changing inputs leave result alone
        held = result;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            src_a = ~src_a; src_b = src_b + 64'h1111; status_word = {32'h89ABCDEF, 32'(c)};
            check("R7 out_valid low", {63'h0, out_valid}, 64'h0);
            check("R8 hold", result, held);
        end

        // R1: only low status bits differ between two back-to-back operations
        @(negedge clk);
        src_a = 64'h0011223344556677; src_b = 64'h8899AABBCCDDEEFF;
        status_word = 64'hFEDCBA98_00000000; in_valid = 1'b1;
        @(negedge clk);
        status_word = 64'hFEDCBA98_DEADBEEF;
        check("R1 first", result, 64'hFFEEDDCCBBAA9988);
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 low bits changed", result, 64'hFFEEDDCCBBAA9988);

        // R4: every lane picks the last pool byte
        @(negedge clk);
        status_word = 64'hFFFFFFFF_00000000; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R4 broadcast last", result, 64'hFFFFFFFFFFFFFFFF);

        // R9: reset in mid-run clears state
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        check("R9 mid-run result", result, 64'h0);
        check("R9 mid-run out_valid", {63'h0, out_valid}, 64'h0);
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule